// File: doc/BRIEF.md
# Dual-Clock Queue with Programmable Fill Thresholds

This block is a first-in first-out queue whose producer and consumer run on unrelated clocks. Data is held in a RAM of 9-bit lanes. Each port is either one lane (9 bits) or two lanes (18 bits) wide, and is set by a parameter. A two-lane word moves its low lane first, so the ports can have different widths and the byte order is kept.

Two active-low warning outputs tell each side that it is close to a limit:
- The consumer-side flag is low while the consumer has at most `n` words left to read.
- The producer-side flag is low while the producer has room for at most `m` more words.

Both offsets are captured while master reset is held. A select input picks either the small default or the large default, and that choice applies to both offsets.

Each side tracks its own position as a word counter. The counter crosses to the other clock domain in gray code through a two-stage synchronizer. Every threshold comparison uses the synchronized copy of the opposite counter, and every flag is registered in the domain of its own port.

Top module: `dcq_fifo`

## Requirements
- R1: While `mrs_n` is low and after it rises, the queue is empty: `rd_empty`=1, `rd_ae_n`=0, `wr_af_n`=1, `wr_full`=0, `rd_data`=0.
- R2: The value of `dflt_sel` held during master reset sets both offsets: n=m=DEF_LO (8) when it is 0, and n=m=DEF_HI (128) when it is 1.
- R3: Once settled, `rd_ae_n` is 1 exactly when (stored lanes / read lanes per word) > n. With equal 9-bit ports it rises after n+1 writes. With a 9-bit write port and an 18-bit read port it rises after 2(n+1) writes. With an 18-bit write port and a 9-bit read port it rises after floor(n/2)+1 writes.
- R4: Once settled, `wr_af_n` is 0 exactly when (free lanes / write lanes per word) <= m. For a queue that is Dw write-words deep, it falls after Dw−m writes.
- R5: For a write sampled on wclk edge e, `wr_af_n` still shows the old state after edge e and shows the new state from edge e+1. For a read sampled on rclk edge e, `rd_ae_n` behaves the same way on rclk.
- R6: An operation on the opposite port changes a flag only after the gray counter has passed through two synchronizer stages. The flag settles within five edges of its own clock.
- R7: `wr_full` is 1 when fewer free lanes remain than one write word needs. `rd_empty` is 1 when fewer stored lanes remain than one read word needs. A write while full is ignored, and a read while empty is ignored: neither moves a pointer and `rd_data` does not change.
- R8: An 18-bit word carries its earlier lane in bits [8:0] and its later lane in bits [17:9]. Lane order is kept across port widths.
- R9: `rd_data` takes the next word on the rclk edge that samples an accepted read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| rclk | input | 1 | Consumer clock |
| mrs_n | input | 1 | Master reset, active low, asynchronous assert |
| dflt_sel | input | 1 | Offset default select, captured during reset |
| wr_en | input | 1 | Write request (wclk) |
| wr_data | input | WR_W | Write word |
| wr_full | output | 1 | No room for one more write word |
| wr_af_n | output | 1 | Almost full, active low, registered on wclk |
| rd_en | input | 1 | Read request (rclk) |
| rd_data | output | RD_W | Registered read word |
| rd_empty | output | 1 | Fewer than one read word stored |
| rd_ae_n | output | 1 | Almost empty, active low, registered on rclk |

## Verification
Three instances run side by side under the same stimulus: equal narrow ports, wide-in/narrow-out, and narrow-in/wide-out. Every single-word step is compared against an arithmetic model of the lane count.
- A full fill sweep past capacity, followed by a full drain sweep past empty, is run under both default selects. The sweep shows where each flag crosses for every width ratio and offset. The steps past capacity and past empty show that the ignored operations really are ignored.
- Within each step, the flag of the operating side is sampled one edge and two edges after the operation, which pins down the registered latency. The opposite-side flag is checked only after settling.
- A final pattern of two writes per read at mid-level checks lane order and read data while the queue neither fills nor empties.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
    localparam int LANE_W = 9;
    localparam int GW     = 16;

    function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dcq_sync.sv
module dcq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/dcq_mem.sv
module dcq_mem #(
    parameter int DEPTH = 512,
    parameter int WL    = 2,
    parameter int RL    = 1
) (
    input  logic                          wclk,
    input  logic                          we,
    input  logic [$clog2(DEPTH)-1:0]      waddr,
    input  logic [WL*dcq_pkg::LANE_W-1:0] wdata,
    input  logic [$clog2(DEPTH)-1:0]      raddr,
    output logic [RL*dcq_pkg::LANE_W-1:0] rdata
);
    import dcq_pkg::*;
    localparam int AW = $clog2(DEPTH);

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            for (int i = 0; i < WL; i++) begin
                mem[waddr + AW'(i)] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    for (genvar i = 0; i < RL; i++) begin : g_rd_lane
        assign rdata[i*LANE_W +: LANE_W] = mem[raddr + AW'(i)];
    end
endmodule

// File: rtl/dcq_wr_ctl.sv
module dcq_wr_ctl #(
    parameter int DEPTH  = 512,
    parameter int WL     = 2,
    parameter int RL     = 1,
    parameter int DEF_LO = 8,
    parameter int DEF_HI = 128,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int WPW   = PW - $clog2(WL),
    localparam int RPW   = PW - $clog2(RL)
) (
    input  logic           wclk,
    input  logic           mrs_n,
    input  logic           dflt_sel,
    input  logic           wr_en,
    input  logic [RPW-1:0] rgray_sync,
    output logic [AW-1:0]  waddr,
    output logic           wr_fire,
    output logic [WPW-1:0] wgray,
    output logic           full,
    output logic           af_n
);
    import dcq_pkg::*;
    localparam int WLB = $clog2(WL);
    localparam int RLB = $clog2(RL);

    typedef struct packed {
        logic [WPW-1:0] wword;
        logic [WPW-1:0] wgray;
        logic           af_n;
    } wst_t;

    wst_t          st_d, st_q;
    logic          sel_q;
    logic [PW-1:0] rlanes, wlanes, fill, free_l, free_w, m_off;

    always_comb begin
        rlanes  = PW'(gray2bin(GW'(rgray_sync))) << RLB;
        wlanes  = PW'(st_q.wword) << WLB;
        fill    = wlanes - rlanes;
        free_l  = PW'(DEPTH) - fill;
        free_w  = free_l >> WLB;
        m_off   = sel_q ? PW'(DEF_HI) : PW'(DEF_LO);
        full    = (free_l < PW'(WL));
        wr_fire = wr_en && !full;
        st_d       = st_q;
        st_d.wword = st_q.wword + WPW'(wr_fire);
        st_d.wgray = WPW'(bin2gray(GW'(st_d.wword)));
        st_d.af_n  = !(free_w <= m_off);
    end

    always_ff @(posedge wclk or negedge mrs_n) begin
        if (!mrs_n) begin
            st_q <= '{wword: '0, wgray: '0, af_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge wclk) begin
        if (!mrs_n) sel_q <= dflt_sel;
    end

    assign waddr = wlanes[AW-1:0];
    assign wgray = st_q.wgray;
    assign af_n  = st_q.af_n;

    a_r7_no_overflow: assert property (@(posedge wclk) disable iff (!mrs_n)
        (wr_en && full) |=> $stable(st_q.wword));
    a_r4_af_fall_needs_write: assert property (@(posedge wclk) disable iff (!mrs_n)
        $fell(af_n) |-> $past(wr_fire, 2));
    a_r7_full_implies_af: assert property (@(posedge wclk) disable iff (!mrs_n)
        full |-> !af_n);
endmodule

// File: rtl/dcq_rd_ctl.sv
module dcq_rd_ctl #(
    parameter int DEPTH  = 512,
    parameter int WL     = 2,
    parameter int RL     = 1,
    parameter int DEF_LO = 8,
    parameter int DEF_HI = 128,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int WPW   = PW - $clog2(WL),
    localparam int RPW   = PW - $clog2(RL),
    localparam int DW    = RL * dcq_pkg::LANE_W
) (
    input  logic           rclk,
    input  logic           mrs_n,
    input  logic           dflt_sel,
    input  logic           rd_en,
    input  logic [WPW-1:0] wgray_sync,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  raddr,
    output logic [RPW-1:0] rgray,
    output logic           empty,
    output logic           ae_n,
    output logic [DW-1:0]  dout
);
    import dcq_pkg::*;
    localparam int WLB = $clog2(WL);
    localparam int RLB = $clog2(RL);

    typedef struct packed {
        logic [RPW-1:0] rword;
        logic [RPW-1:0] rgray;
        logic           ae_n;
        logic [DW-1:0]  dout;
    } rst_t;

    rst_t          st_d, st_q;
    logic          sel_q, rd_fire;
    logic [PW-1:0] wlanes, rlanes, fill, rwords, n_off;

    always_comb begin
        wlanes  = PW'(gray2bin(GW'(wgray_sync))) << WLB;
        rlanes  = PW'(st_q.rword) << RLB;
        fill    = wlanes - rlanes;
        rwords  = fill >> RLB;
        n_off   = sel_q ? PW'(DEF_HI) : PW'(DEF_LO);
        empty   = (fill < PW'(RL));
        rd_fire = rd_en && !empty;
        st_d       = st_q;
        st_d.rword = st_q.rword + RPW'(rd_fire);
        st_d.rgray = RPW'(bin2gray(GW'(st_d.rword)));
        st_d.ae_n  = (rwords > n_off);
        st_d.dout  = rd_fire ? mem_rdata : st_q.dout;
    end

    always_ff @(posedge rclk or negedge mrs_n) begin
        if (!mrs_n) begin
            st_q <= '{rword: '0, rgray: '0, ae_n: 1'b0, dout: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge rclk) begin
        if (!mrs_n) sel_q <= dflt_sel;
    end

    assign raddr = rlanes[AW-1:0];
    assign rgray = st_q.rgray;
    assign ae_n  = st_q.ae_n;
    assign dout  = st_q.dout;

    a_r7_no_underflow: assert property (@(posedge rclk) disable iff (!mrs_n)
        (rd_en && empty) |=> ($stable(st_q.rword) && $stable(dout)));
    a_r3_ae_fall_needs_read: assert property (@(posedge rclk) disable iff (!mrs_n)
        $fell(ae_n) |-> $past(rd_fire, 2));
    a_r7_empty_implies_ae: assert property (@(posedge rclk) disable iff (!mrs_n)
        empty |-> !ae_n);
endmodule

// File: rtl/dcq_fifo.sv
module dcq_fifo #(
    parameter int DEPTH  = 512,
    parameter int WR_W   = 18,
    parameter int RD_W   = 9,
    parameter int DEF_LO = 8,
    parameter int DEF_HI = 128
) (
    input  logic            wclk,
    input  logic            rclk,
    input  logic            mrs_n,
    input  logic            dflt_sel,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic            wr_full,
    output logic            wr_af_n,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_empty,
    output logic            rd_ae_n
);
    localparam int WL  = WR_W / dcq_pkg::LANE_W;
    localparam int RL  = RD_W / dcq_pkg::LANE_W;
    localparam int AW  = $clog2(DEPTH);
    localparam int PW  = AW + 1;
    localparam int WPW = PW - $clog2(WL);
    localparam int RPW = PW - $clog2(RL);

    logic [AW-1:0]  waddr, raddr;
    logic           wr_fire;
    logic [WPW-1:0] wgray, wgray_s;
    logic [RPW-1:0] rgray, rgray_s;
    logic [RD_W-1:0] mem_rdata;

    dcq_mem #(.DEPTH(DEPTH), .WL(WL), .RL(RL)) mem_i (
        .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    dcq_sync #(.W(RPW)) r2w_i (.clk(wclk), .rst_n(mrs_n), .d(rgray), .q(rgray_s));
    dcq_sync #(.W(WPW)) w2r_i (.clk(rclk), .rst_n(mrs_n), .d(wgray), .q(wgray_s));

    dcq_wr_ctl #(.DEPTH(DEPTH), .WL(WL), .RL(RL), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) wr_i (
        .wclk(wclk), .mrs_n(mrs_n), .dflt_sel(dflt_sel), .wr_en(wr_en),
        .rgray_sync(rgray_s), .waddr(waddr), .wr_fire(wr_fire), .wgray(wgray),
        .full(wr_full), .af_n(wr_af_n)
    );

    dcq_rd_ctl #(.DEPTH(DEPTH), .WL(WL), .RL(RL), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) rd_i (
        .rclk(rclk), .mrs_n(mrs_n), .dflt_sel(dflt_sel), .rd_en(rd_en),
        .wgray_sync(wgray_s), .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray),
        .empty(rd_empty), .ae_n(rd_ae_n), .dout(rd_data)
    );
endmodule

// File: tb/dcq_fifo_tb_top.sv
module dcq_fifo_tb_top;
    localparam int DEPTH = 512;

    logic wclk = 1'b0, rclk = 1'b0;
    logic mrs_n = 1'b0, dflt_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [17:0] din = '0;
    logic [2:0]  full_v, af_v, empty_v, ae_v;
    logic [17:0] dout_v [3];

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    for (genvar k = 0; k < 3; k++) begin : g_cfg
        localparam int WW = (k == 1) ? 18 : 9;
        localparam int RW = (k == 2) ? 18 : 9;
        logic [RW-1:0] rdat;
        dcq_fifo #(.DEPTH(DEPTH), .WR_W(WW), .RD_W(RW)) dut_i (
            .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .dflt_sel(dflt_sel),
            .wr_en(wr_en), .wr_data(din[WW-1:0]), .wr_full(full_v[k]), .wr_af_n(af_v[k]),
            .rd_en(rd_en), .rd_data(rdat), .rd_empty(empty_v[k]), .rd_ae_n(ae_v[k])
        );
        assign dout_v[k] = 18'(rdat);
    end

    int nchk = 0, nerr = 0;
    int cnt [3];
    int hd [3];
    int tl [3];
    logic [8:0]  mq [3][DEPTH];
    logic [17:0] last_d [3];
    int n_off = 8, m_off = 8;

    function automatic int wl(int k); return (k == 1) ? 2 : 1; endfunction
    function automatic int rl(int k); return (k == 2) ? 2 : 1; endfunction
    function automatic logic exp_ae(int k); return (cnt[k] / rl(k)) > n_off; endfunction
    function automatic logic exp_af(int k); return !(((DEPTH - cnt[k]) / wl(k)) <= m_off); endfunction
    function automatic logic exp_full(int k); return (DEPTH - cnt[k]) < wl(k); endfunction
    function automatic logic exp_empty(int k); return cnt[k] < rl(k); endfunction

    task automatic chk(input string tag, input int k, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s cfg%0d actual=%0h expected=%0h", tag, k, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge rclk);
        repeat (5) @(negedge wclk);
        for (int k = 0; k < 3; k++) begin
            chk("R2 R3 R6 ae", k, 32'(ae_v[k]), 32'(exp_ae(k)));
            chk("R2 R4 R6 af", k, 32'(af_v[k]), 32'(exp_af(k)));
            chk("R7 full", k, 32'(full_v[k]), 32'(exp_full(k)));
            chk("R7 empty", k, 32'(empty_v[k]), 32'(exp_empty(k)));
        end
    endtask

    task automatic do_reset(input logic sel);
        @(negedge wclk);
        mrs_n = 1'b0; dflt_sel = sel; wr_en = 1'b0; rd_en = 1'b0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        for (int k = 0; k < 3; k++) begin
            cnt[k] = 0; hd[k] = 0; tl[k] = 0; last_d[k] = '0;
            chk("R1 empty in reset", k, 32'(empty_v[k]), 32'd1);
            chk("R1 ae_n in reset", k, 32'(ae_v[k]), 32'd0);
        end
        mrs_n = 1'b1;
        n_off = sel ? 128 : 8;
        m_off = n_off;
        repeat (3) @(negedge rclk);
        repeat (3) @(negedge wclk);
        for (int k = 0; k < 3; k++) begin
            chk("R1 empty", k, 32'(empty_v[k]), 32'd1);
            chk("R1 ae_n", k, 32'(ae_v[k]), 32'd0);
            chk("R1 af_n", k, 32'(af_v[k]), 32'd1);
            chk("R1 full", k, 32'(full_v[k]), 32'd0);
            chk("R1 data", k, 32'(dout_v[k]), 32'd0);
        end
    endtask

    task automatic do_write(input logic [17:0] d);
        logic oaf [3];
        @(negedge wclk);
        din = d; wr_en = 1'b1;
        for (int k = 0; k < 3; k++) oaf[k] = exp_af(k);
        @(negedge wclk);
        wr_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (!exp_full(k)) begin
                for (int i = 0; i < wl(k); i++) begin
                    mq[k][tl[k]] = d[9*i +: 9];
                    tl[k] = (tl[k] + 1) % DEPTH;
                end
                cnt[k] += wl(k);
            end
            chk("R5 af_n one edge", k, 32'(af_v[k]), 32'(oaf[k]));
        end
        @(negedge wclk);
        for (int k = 0; k < 3; k++) begin
            chk("R5 af_n two edges", k, 32'(af_v[k]), 32'(exp_af(k)));
            chk("R7 full after write", k, 32'(full_v[k]), 32'(exp_full(k)));
        end
        settle();
    endtask

    task automatic do_read();
        logic oae [3];
        @(negedge rclk);
        rd_en = 1'b1;
        for (int k = 0; k < 3; k++) oae[k] = exp_ae(k);
        @(negedge rclk);
        rd_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (!exp_empty(k)) begin
                logic [17:0] e;
                e = '0;
                for (int i = 0; i < rl(k); i++) begin
                    e[9*i +: 9] = mq[k][hd[k]];
                    hd[k] = (hd[k] + 1) % DEPTH;
                end
                cnt[k] -= rl(k);
                last_d[k] = e;
                chk("R8 R9 data", k, 32'(dout_v[k]), 32'(e));
            end else begin
                chk("R7 data held on empty read", k, 32'(dout_v[k]), 32'(last_d[k]));
            end
            chk("R5 ae_n one edge", k, 32'(ae_v[k]), 32'(oae[k]));
        end
        @(negedge rclk);
        for (int k = 0; k < 3; k++) begin
            chk("R5 ae_n two edges", k, 32'(ae_v[k]), 32'(exp_ae(k)));
            chk("R9 data held", k, 32'(dout_v[k]), 32'(last_d[k]));
        end
        settle();
    endtask

    function automatic logic [17:0] pat(int i);
        return {9'(i * 7 + 3), 9'(i)};
    endfunction

    initial begin
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            for (int i = 0; i < DEPTH + 2; i++) do_write(pat(i + s * 100));
            for (int i = 0; i < DEPTH + 2; i++) do_read();
        end
        for (int i = 0; i < 60; i++) begin
            do_write(pat(i * 5 + 11));
            do_write(pat(i * 3 + 200));
            do_read();
        end
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #900000;
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule